// File: doc/BRIEF.md
# Word Shift-Immediate Execute Unit

This unit handles one operation of a 64-bit integer pipeline: a logical right shift by an immediate, applied to the low 32-bit word of a source operand. It receives a 32-bit instruction word together with the source value, which has already been read from the register file. It decodes the instruction and shifts the low word right, filling with zeros. It then widens the 32-bit result to the full datapath by copying the new bit 31 into every upper bit.

The unit presents a combinational source-register index so that the register read can be steered. The rest of its output is registered one cycle after an input strobe: result, destination index, write enable and an illegal-instruction flag. An instruction word that belongs to another operation still returns a valid beat, with both write enable and the illegal flag low. The next stage reads that as "not mine".

Top module: `wshimm_exec`

## Requirements
- R1: The operation is selected only when instruction bits 6..0 equal 7'b0011011 and bits 14..12 equal 3'b101. Any other opcode or funct3 gives a valid output beat with out_we=0, out_illegal=0 and out_result=0.
- R2: On a matching opcode and funct3, with bit 25 clear and any of bits 31..26 set, the word is treated as another operation: out_we=0, out_illegal=0, out_result=0.
- R3: On a matching opcode and funct3 with bit 25 set, the encoding is reserved. The unit gives out_illegal=1, out_we=0 and out_result=0. This takes priority over R2.
- R4: The shift amount is bits 24..20 (0 to 31). Only in_src[31:0] is shifted, with zeros entering at bit 31. in_src[63:32] has no effect on the result.
- R5: Result bits 63..32 all equal bit 31 of the shifted word.
- R6: A shift amount of 0 returns in_src[31:0] unchanged in the low half, with the upper half rebuilt from bit 31.
- R7: out_rd carries bits 11..7 of the accepted word. src_sel combinationally shows bits 19..15 of in_instr.
- R8: A legal operation whose destination field is 0 keeps out_we=0, while still returning the computed result.
- R9: out_valid follows in_valid one clock later. While out_valid is 0, out_we and out_illegal are 0. Back-to-back inputs give back-to-back outputs.
- R10: A synchronous active-high reset clears out_valid, out_we, out_illegal and out_result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| in_instr | input | 32 | Instruction word |
| in_src | input | 64 | Source operand, already read |
| src_sel | output | 5 | Source register index (combinational) |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_result | output | 64 | Sign-extended shifted word |
| out_rd | output | 5 | Destination register index |
| out_we | output | 1 | Register write enable |
| out_illegal | output | 1 | Reserved-encoding exception flag |

## Verification
Two conditions can land in the same beat: the reserved-encoding exception, and write suppression for destination 0. In that beat the flag must still rise while the write stays off. The bench provokes this by issuing a word with bit 25 set and a zero destination field. It issues a second word that adds a nonzero bit 30, so the reserved case also meets the foreign-funct7 case. The monitor's scoreboard expects out_illegal=1, out_we=0 and a zero result for both. It also checks a legal zero-destination word in the very next cycle, which must carry a result with the write suppressed.

// File: rtl/wshimm_pkg.sv
package wshimm_pkg;

   localparam int          INSTR_W      = 32;
   localparam int          REG_IDX_W    = 5;
   localparam logic [6:0]  OPC_WORD_IMM = 7'b0011011;
   localparam logic [2:0]  F3_SHR       = 3'b101;

   typedef enum logic [1:0] {
      CLS_NONE = 2'd0,
      CLS_HIT  = 2'd1,
      CLS_RSV  = 2'd2
   } wcls_e;

endpackage

// File: rtl/wshimm_decode.sv
module wshimm_decode
   import wshimm_pkg::*;
#(
   parameter int SHAMT_W = 5
) (
   input  logic [INSTR_W-1:0]   instr,
   output logic [SHAMT_W-1:0]   shamt,
   output logic [REG_IDX_W-1:0] rd_idx,
   output logic [REG_IDX_W-1:0] rs_idx,
   output wcls_e                cls
);
   localparam int RSV_BIT = 20 + SHAMT_W;

   logic op_ok;
   logic rsv_bit;
   logic upper_clear;

   assign shamt       = instr[20 +: SHAMT_W];
   assign rd_idx      = instr[11:7];
   assign rs_idx      = instr[19:15];
   assign op_ok       = (instr[6:0] == OPC_WORD_IMM) && (instr[14:12] == F3_SHR);
   assign rsv_bit     = instr[RSV_BIT];
   assign upper_clear = (instr[INSTR_W-1:RSV_BIT+1] == '0);

   always_comb begin
      cls = CLS_NONE;
      if (op_ok) begin
         if (rsv_bit)          cls = CLS_RSV;
         else if (upper_clear) cls = CLS_HIT;
      end
   end

endmodule

// File: rtl/wshimm_shifter.sv
module wshimm_shifter #(
   parameter int XLEN       = 64,
   parameter int WLEN       = 32,
   parameter int SHIFT_IMPL = 1,
   localparam int SHAMT_W   = $clog2(WLEN)
) (
   input  logic [WLEN-1:0]    word_in,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [XLEN-1:0]    result
);
   logic [WLEN-1:0] shifted;

   generate
      if (SHIFT_IMPL == 0) begin : g_flat
         assign shifted = word_in >> shamt;
      end else begin : g_log
         logic [WLEN-1:0] stg [0:SHAMT_W];
         assign stg[0] = word_in;
         for (genvar i = 0; i < SHAMT_W; i++) begin : g_stage
            assign stg[i+1] = shamt[i] ? (stg[i] >> (1 << i)) : stg[i];
         end
         assign shifted = stg[SHAMT_W];
      end
   endgenerate

   assign result = {{(XLEN-WLEN){shifted[WLEN-1]}}, shifted};

   always_comb begin
      if (!$isunknown(shamt) && (shamt != '0))
         p_zero_fill_r4: assert (shifted[WLEN-1] == 1'b0);
   end

endmodule

// File: rtl/wshimm_exec.sv
module wshimm_exec
   import wshimm_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int WLEN       = 32,
   parameter int SHIFT_IMPL = 1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  in_valid,
   input  logic [INSTR_W-1:0]    in_instr,
   input  logic [XLEN-1:0]       in_src,
   output logic [REG_IDX_W-1:0]  src_sel,
   output logic                  out_valid,
   output logic [XLEN-1:0]       out_result,
   output logic [REG_IDX_W-1:0]  out_rd,
   output logic                  out_we,
   output logic                  out_illegal
);
   localparam int SHAMT_W = $clog2(WLEN);

   generate
      if (WLEN != 32) begin : g_bad_wlen
         $error("wshimm_exec: WLEN must be 32 to match the immediate layout");
      end
      if (XLEN <= WLEN) begin : g_bad_xlen
         $error("wshimm_exec: XLEN must exceed WLEN");
      end
      if (SHIFT_IMPL < 0 || SHIFT_IMPL > 1) begin : g_bad_impl
         $error("wshimm_exec: SHIFT_IMPL must be 0 or 1");
      end
   endgenerate

   logic [SHAMT_W-1:0]   shamt;
   logic [REG_IDX_W-1:0] rd_idx;
   wcls_e                cls;
   logic [XLEN-1:0]      ext_res;
   logic                 unused_src_hi;

   assign unused_src_hi = ^in_src[XLEN-1:WLEN];

   wshimm_decode #(.SHAMT_W(SHAMT_W)) u_dec (
      .instr  (in_instr),
      .shamt  (shamt),
      .rd_idx (rd_idx),
      .rs_idx (src_sel),
      .cls    (cls)
   );

   wshimm_shifter #(.XLEN(XLEN), .WLEN(WLEN), .SHIFT_IMPL(SHIFT_IMPL)) u_shf (
      .word_in (in_src[WLEN-1:0]),
      .shamt   (shamt),
      .result  (ext_res)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         out_we      <= 1'b0;
         out_illegal <= 1'b0;
         out_result  <= '0;
         out_rd      <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_rd      <= rd_idx;
            out_illegal <= (cls == CLS_RSV);
            out_we      <= (cls == CLS_HIT) && (rd_idx != '0);
            out_result  <= (cls == CLS_HIT) ? ext_res : '0;
         end else begin
            out_we      <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
         end
      end
   end

   p_latency_r9: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   p_gap_r9: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!out_we && !out_illegal));
   p_foreign_r1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_instr[6:0] != OPC_WORD_IMM)) |=> (!out_we && !out_illegal));
   p_rsv_flag_r3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (in_instr[6:0] == OPC_WORD_IMM) && (in_instr[14:12] == F3_SHR)
       && in_instr[25]) |=> (out_illegal && !out_we));
   p_zero_dest_r8: assert property (@(posedge clk) disable iff (rst)
      out_we |-> (out_rd != '0));
   p_sign_fill_r5: assert property (@(posedge clk) disable iff (rst)
      out_we |-> (out_result[XLEN-1:WLEN] == {(XLEN-WLEN){out_result[WLEN-1]}}));

endmodule

// File: tb/sim_wshimm_exec.sv
module sim_wshimm_exec;

   typedef struct packed {
      logic [63:0] result;
      logic [4:0]  rd;
      logic        we;
      logic        illegal;
      int          cyc;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_instr = '0;
   logic [63:0] in_src = '0;
   logic [4:0]  src_sel;
   logic        out_valid;
   logic [63:0] out_result;
   logic [4:0]  out_rd;
   logic        out_we;
   logic        out_illegal;

   int    checks = 0;
   int    errors = 0;
   int    cyc    = 0;
   bit    done   = 0;
   exp_t  exp_q[$];
   string tag_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) cyc++;

   wshimm_exec u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
      .in_src(in_src), .src_sel(src_sel), .out_valid(out_valid),
      .out_result(out_result), .out_rd(out_rd), .out_we(out_we),
      .out_illegal(out_illegal)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input logic [6:0] f7, input logic [4:0] sh,
                                      input logic [4:0] rs, input logic [2:0] f3,
                                      input logic [4:0] rd, input logic [6:0] op);
      return {f7, sh, rs, f3, rd, op};
   endfunction

   task automatic issue(input logic [31:0] ins, input logic [63:0] src, input string tag);
      exp_t e;
      logic [31:0] w;
      bit match;
      bit rsv;
      bit hit;
      @(negedge clk);
      in_valid = 1'b1;
      in_instr = ins;
      in_src   = src;
      match = (ins[6:0] == 7'b0011011) && (ins[14:12] == 3'b101);
      rsv   = match && ins[25];
      hit   = match && !ins[25] && (ins[31:26] == 6'd0);
      w     = src[31:0] >> ins[24:20];
      e.rd      = ins[11:7];
      e.illegal = rsv;
      e.we      = hit && (ins[11:7] != 5'd0);
      e.result  = hit ? {{32{w[31]}}, w} : 64'd0;
      e.cyc     = cyc;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #1;
      chk(src_sel == ins[19:15], "R7 src_sel", {59'd0, src_sel}, {59'd0, ins[19:15]});
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 unexpected out_valid", 64'd1, 64'd0);
            end else begin
               exp_t e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(cyc == e.cyc + 1, {t, " latency"}, 64'(cyc), 64'(e.cyc + 1));
               chk(out_result == e.result, {t, " result"}, out_result, e.result);
               chk(out_rd == e.rd, {t, " rd"}, {59'd0, out_rd}, {59'd0, e.rd});
               chk(out_we == e.we, {t, " we"}, {63'd0, out_we}, {63'd0, e.we});
               chk(out_illegal == e.illegal, {t, " illegal"},
                   {63'd0, out_illegal}, {63'd0, e.illegal});
            end
         end else begin
            chk(!out_we && !out_illegal, "R9 idle quiet",
                {62'd0, out_we, out_illegal}, 64'd0);
         end
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [6:0] OP  = 7'b0011011;
   localparam logic [2:0] F3  = 3'b101;

   initial begin
      in_valid = 1'b1;
      in_instr = mk(7'd0, 5'd3, 5'd1, F3, 5'd4, OP);
      in_src   = 64'hFFFF_FFFF_FFFF_FFFF;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!out_valid && !out_we && !out_illegal && out_result == 64'd0, "R10 reset",
          {61'd0, out_valid, out_we, out_illegal} | out_result, 64'd0);
      rst = 1'b0;
      in_valid = 1'b0;
      idle();

      // R4: upper source half ignored, zeros fill from the top
      issue(mk(7'd0, 5'd4, 5'd11, F3, 5'd10, OP), 64'h1234_5678_9ABC_DEF0, "R4 shift4");
      issue(mk(7'd0, 5'd31, 5'd2, F3, 5'd3, OP), 64'hFFFF_FFFF_8000_0000, "R4 shift31");
      issue(mk(7'd0, 5'd1, 5'd2, F3, 5'd3, OP), 64'hAAAA_AAAA_FFFF_FFFF, "R4 shift1");
      // R5/R6: zero shift, sign rebuilt
      issue(mk(7'd0, 5'd0, 5'd5, F3, 5'd6, OP), 64'h0000_0000_8000_0000, "R6 zero-neg");
      issue(mk(7'd0, 5'd0, 5'd5, F3, 5'd6, OP), 64'hFFFF_FFFF_7FFF_FFFF, "R6 zero-pos");
      issue(mk(7'd0, 5'd0, 5'd7, F3, 5'd31, OP), 64'h0123_4567_C000_0001, "R5 extend");
      idle();
      // R8: legal write to destination 0
      issue(mk(7'd0, 5'd2, 5'd1, F3, 5'd0, OP), 64'h0000_0000_0000_0100, "R8 rd0");
      // R3: reserved bit, alone, with rd 0, with bit 30 set
      issue(mk(7'b0000001, 5'd2, 5'd1, F3, 5'd9, OP), 64'h0000_0000_0000_0100, "R3 rsv");
      issue(mk(7'b0000001, 5'd2, 5'd1, F3, 5'd0, OP), 64'h0000_0000_0000_0100, "R3 rsv-rd0");
      issue(mk(7'b0100001, 5'd5, 5'd1, F3, 5'd9, OP), 64'h0000_0000_8000_0000, "R3 rsv-prio");
      issue(mk(7'd0, 5'd2, 5'd1, F3, 5'd0, OP), 64'h0000_0000_0000_0100, "R8 rd0-next");
      // R2: foreign funct7
      issue(mk(7'b0100000, 5'd5, 5'd1, F3, 5'd9, OP), 64'h0000_0000_8000_0000, "R2 f7");
      issue(mk(7'b1000000, 5'd0, 5'd1, F3, 5'd9, OP), 64'h0000_0000_8000_0000, "R2 f7top");
      // R1: foreign opcode and funct3
      issue(mk(7'd0, 5'd4, 5'd1, F3, 5'd9, 7'b0010011), 64'h0000_0000_FFFF_0000, "R1 opcode");
      issue(mk(7'd0, 5'd4, 5'd1, 3'b001, 5'd9, OP), 64'h0000_0000_FFFF_0000, "R1 funct3");
      idle();
      idle();
      // R4/R7: every shift amount, varied register fields
      for (int s = 0; s < 32; s++) begin
         issue(mk(7'd0, 5'(s), 5'(31 - s), F3, 5'(s + 1), OP),
               64'h5A5A_0F0F_DEAD_BEEF ^ 64'(s), "R4 sweep");
         if (s % 8 == 7) idle();
      end
      idle();
      idle();
      idle();
      chk(exp_q.size() == 0, "R9 drained", 64'(exp_q.size()), 64'd0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule